// File: doc/BRIEF.md
# BPSK Bit-to-Sample Modulator

This block turns a serial stream of already framed packet bits into sample words for the in-phase and quadrature inputs of a pair of digital-to-analog converters. Bits arrive one at a time over a valid/ready handshake. Each accepted bit becomes a run of eight samples, one per converter clock, that trace one full period of a full-scale sinusoid. Four samples make up each half period. A logic 1 sends the sinusoid with its normal sign and a logic 0 sends it inverted, which is binary phase-shift keying.

The in-phase and quadrature outputs always carry the same sample. A receiver whose carrier has drifted in phase against the transmitter can therefore still find the data on at least one of its two channels. Each bit starts its sinusoid at phase zero. The block asks for the next bit only on the last sample of the current one, so a steady supply of bits produces one bit every eight clocks with no gap. When no bit is waiting at a bit boundary, both outputs drop to zero and stay there until a bit arrives.

Top module: `bpsk_bit_modulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both sample outputs are zero and `bit_ready` is high.
- R2: After a logic 1 is accepted on a clock edge, the following eight output samples are round(F·sin(2πk/8)) for k = 0 to 7, with F = 2^(SAMPLE_W-1)-1. For the default width this is 0, 23170, 32767, 23170, 0, -23170, -32767, -23170 in two's complement.
- R3: After a logic 0 is accepted, the following eight samples are the exact negation of the R2 sequence.
- R4: `dac_i` and `dac_q` are equal in every cycle.
- R5: `bit_ready` is high only when the block is idle or is showing the eighth sample (k = 7) of a bit. Values on `bit_valid` and `bit_data` while `bit_ready` is low do not change the outputs.
- R6: A bit offered while the eighth sample of the previous bit is showing is accepted at once. Its k = 0 sample follows with no idle cycle, so a continuous supply gives exactly one bit per eight clocks.
- R7: If no bit is offered while `bit_ready` is high, both outputs are zero from the next cycle on and stay zero until a bit is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | The offered data bit |
| bit_ready | output | 1 | The block takes the offered bit on this edge |
| dac_i | output | SAMPLE_W | In-phase sample, two's complement |
| dac_q | output | SAMPLE_W | Quadrature sample, two's complement |

## Verification
The hardest case to reach from the ports is a change on `bit_data` while `bit_valid` is held high and `bit_ready` is low. This shows whether the block really ignores the input in the middle of a bit. The bench reaches it with a mode that keeps the handshake asserted for the whole bit period and drives the inverted bit until ready rises, so any early capture shows up as a flipped waveform. The second mode sweeps all 5-bit words back to back, which exercises the no-gap handover at k = 7. The third mode adds idle cycles between bits to cover the return to zero and the restart from idle.

// File: rtl/bpsk_mod_pkg.sv
package bpsk_mod_pkg;

    // Samples per data bit; four per half period of the carrier sinusoid.
    localparam int unsigned SAMPLES_PER_BIT = 8;
    localparam int unsigned PHASE_W = $clog2(SAMPLES_PER_BIT);

    // One eighth-period point of a full-scale sine for a given word width.
    // 46341/65536 approximates 1/sqrt(2); rounding is to nearest.
    function automatic longint wave_point(input int k, input int width);
        longint full;
        longint diag;
        full = (longint'(1) <<< (width - 1)) - 1;
        diag = (full * 46341 + 32768) >>> 16;
        case (k)
            1, 3:    wave_point = diag;
            2:       wave_point = full;
            5, 7:    wave_point = -diag;
            6:       wave_point = -full;
            default: wave_point = 0;
        endcase
    endfunction

endpackage

// File: rtl/bpsk_wave_lut.sv
module bpsk_wave_lut #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic [bpsk_mod_pkg::PHASE_W-1:0] phase,
    output logic signed [SAMPLE_W-1:0]       sample
);
    localparam int unsigned N = bpsk_mod_pkg::SAMPLES_PER_BIT;

    logic signed [SAMPLE_W-1:0] table_w [N];

    for (genvar k = 0; k < N; k++) begin : g_point
        localparam longint VAL = bpsk_mod_pkg::wave_point(k, SAMPLE_W);
        assign table_w[k] = SAMPLE_W'(VAL);
    end

    assign sample = table_w[phase];
endmodule

// File: rtl/bpsk_polarity.sv
module bpsk_polarity #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                       active,
    input  logic                       data_bit,
    input  logic signed [SAMPLE_W-1:0] base,
    output logic signed [SAMPLE_W-1:0] sample
);
    always_comb begin
        if (!active) begin
            sample = '0;
        end else if (data_bit) begin
            sample = base;
        end else begin
            sample = -base;
        end
    end
endmodule

// File: rtl/bpsk_accept_ctl.sv
module bpsk_accept_ctl (
    input  logic                             active,
    input  logic [bpsk_mod_pkg::PHASE_W-1:0] phase,
    input  logic                             valid,
    output logic                             ready,
    output logic                             take
);
    localparam logic [bpsk_mod_pkg::PHASE_W-1:0] LAST =
        bpsk_mod_pkg::PHASE_W'(bpsk_mod_pkg::SAMPLES_PER_BIT - 1);

    assign ready = !active || (phase == LAST);
    assign take  = ready && valid;
endmodule

// File: rtl/bpsk_bit_modulator.sv
module bpsk_bit_modulator #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_valid,
    input  logic                       bit_data,
    output logic                       bit_ready,
    output logic signed [SAMPLE_W-1:0] dac_i,
    output logic signed [SAMPLE_W-1:0] dac_q
);
    localparam int unsigned PW = bpsk_mod_pkg::PHASE_W;
    localparam logic [PW-1:0] LAST = PW'(bpsk_mod_pkg::SAMPLES_PER_BIT - 1);

    typedef struct packed {
        logic                       active;
        logic [PW-1:0]              phase;
        logic                       data_bit;
        logic signed [SAMPLE_W-1:0] samp_i;
        logic signed [SAMPLE_W-1:0] samp_q;
    } mod_state_t;

    mod_state_t st_q, st_d;

    logic                       take;
    logic signed [SAMPLE_W-1:0] base_w;
    logic signed [SAMPLE_W-1:0] signed_w;

    bpsk_accept_ctl u_accept (
        .active (st_q.active),
        .phase  (st_q.phase),
        .valid  (bit_valid),
        .ready  (bit_ready),
        .take   (take)
    );

    bpsk_wave_lut #(.SAMPLE_W(SAMPLE_W)) u_lut (
        .phase  (st_d.phase),
        .sample (base_w)
    );

    bpsk_polarity #(.SAMPLE_W(SAMPLE_W)) u_pol (
        .active   (st_d.active),
        .data_bit (st_d.data_bit),
        .base     (base_w),
        .sample   (signed_w)
    );

    // Next-state: sequencing, then the sample for the coming phase.
    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.active   = 1'b1;
            st_d.phase    = '0;
            st_d.data_bit = bit_data;
        end else if (st_q.active) begin
            if (st_q.phase == LAST) begin
                st_d.active = 1'b0;
                st_d.phase  = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
        st_d.samp_i = signed_w;
        st_d.samp_q = signed_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_i = st_q.samp_i;
    assign dac_q = st_q.samp_q;
endmodule

// File: rtl/bpsk_mod_chk.sv
module bpsk_mod_chk #(
    parameter int unsigned SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bit_valid,
    input logic                       bit_data,
    input logic                       bit_ready,
    input logic signed [SAMPLE_W-1:0] dac_i,
    input logic signed [SAMPLE_W-1:0] dac_q
);
    localparam logic signed [SAMPLE_W-1:0] PEAK = SAMPLE_W'((longint'(1) <<< (SAMPLE_W - 1)) - 1);

    // Independent tracker of the phase currently on the outputs.
    logic       trk_busy;
    logic [2:0] trk_cnt;
    logic       trk_bit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_busy <= 1'b0;
            trk_cnt  <= '0;
            trk_bit  <= 1'b0;
        end else if (bit_valid && bit_ready) begin
            trk_busy <= 1'b1;
            trk_cnt  <= '0;
            trk_bit  <= bit_data;
        end else if (trk_busy) begin
            if (trk_cnt == 3'd7) trk_busy <= 1'b0;
            trk_cnt <= trk_cnt + 3'd1;
        end
    end

    // R4
    iq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_i == dac_q);

    // R5
    ready_mid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_busy && trk_cnt != 3'd7) |-> !bit_ready);

    // R6
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_busy && trk_cnt == 3'd7) |-> bit_ready);

    // R2
    peak_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_busy && trk_cnt == 3'd2 && trk_bit) |-> dac_i == PEAK);

    // R3
    peak_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_busy && trk_cnt == 3'd2 && !trk_bit) |-> dac_i == -PEAK);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ready && !bit_valid) |=> (dac_i == '0 && dac_q == '0));

    // R6
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ready && bit_valid) |=> dac_i == '0);
endmodule

bind bpsk_bit_modulator bpsk_mod_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .bit_ready (bit_ready),
    .dac_i     (dac_i),
    .dac_q     (dac_q)
);

// File: tb/tb_bpsk_bit_modulator.sv
`timescale 1ns/1ps
module tb_bpsk_bit_modulator;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_data = 1'b0;
    logic bit_ready;
    logic signed [W-1:0] dac_i;
    logic signed [W-1:0] dac_q;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit checking = 1'b0;

    always #2.5 clk = ~clk;

    bpsk_bit_modulator #(.SAMPLE_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .bit_ready (bit_ready),
        .dac_i     (dac_i),
        .dac_q     (dac_q)
    );

    // Reference: what is on the outputs after each edge.
    logic m_active;
    int   m_phase;
    logic m_bit;
    wire  m_ready = !m_active || (m_phase == 7);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active <= 1'b0;
            m_phase  <= 0;
            m_bit    <= 1'b0;
        end else if (bit_valid && m_ready) begin
            m_active <= 1'b1;
            m_phase  <= 0;
            m_bit    <= bit_data;
        end else if (m_active) begin
            if (m_phase == 7) m_active <= 1'b0;
            m_phase <= (m_phase + 1) % 8;
        end
    end

    function automatic int expect_sample(input int k, input logic b);
        real full, v, r;
        full = real'((64'sd1 <<< (W - 1)) - 1);
        v = full * $sin(2.0 * 3.14159265358979 * real'(k) / 8.0);
        if (v >= 0.0) r = $floor(v + 0.5);
        else          r = -$floor(-v + 0.5);
        expect_sample = b ? $rtoi(r) : -$rtoi(r);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            int e;
            // R4
            check(dac_i == dac_q, "R4 i/q equal", int'(dac_q), int'(dac_i));
            if (!m_active) begin
                // R7
                check(dac_i == 0, "R7 idle zero", int'(dac_i), 0);
            end else begin
                e = expect_sample(m_phase, m_bit);
                if (m_bit) check(int'(dac_i) == e, "R2 logic-1 sample", int'(dac_i), e);
                else       check(int'(dac_i) == e, "R3 logic-0 sample", int'(dac_i), e);
            end
            if (m_active && m_phase == 7)
                check(bit_ready == 1'b1, "R6 ready at last sample", int'(bit_ready), 1);
            else
                check(bit_ready == m_ready, "R5 ready timing", int'(bit_ready), int'(m_ready));
        end
    end

    // Called at a negedge; returns at the negedge after the bit is taken.
    task automatic send_bit(input logic b, input bit noisy);
        bit took;
        took = 1'b0;
        while (!took) begin
            bit_valid = 1'b1;
            bit_data  = (noisy && !bit_ready) ? ~b : b;
            took      = bit_ready;
            @(negedge clk);
        end
        bit_valid = 1'b0;
        bit_data  = noisy ? ~b : 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(dac_i == 0 && dac_q == 0, "R1 reset outputs", int'(dac_i), 0);
        check(bit_ready == 1'b1, "R1 reset ready", int'(bit_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(dac_i == 0 && bit_ready == 1'b1, "R1 first cycle after reset", int'(dac_i), 0);
        checking = 1'b1;
        for (int mode = 0; mode < 3; mode++) begin
            for (int w = 0; w < 32; w++) begin
                for (int i = 0; i < 5; i++) begin
                    send_bit(w[i], mode == 1);
                    if (mode == 2) repeat ((w % 3) * 5) @(negedge clk);
                end
            end
            repeat (12) @(negedge clk);
        end
        checking = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule